// File: doc/BRIEF.md
# Lockstep Delay Compare Checker

This block watches two identical processor cores that execute the same program, with the second core trailing the first by exactly two clocks. Each core presents its bus address, write data, read and write strobes, and general-purpose outputs. The leading core's bundle passes through a two-stage register line, so on every clock it sits beside the trailing core's current bundle. The two are then compared field by field, and a field is only compared while the strobe that gives it meaning is active.

The first mismatch raises a sticky fault indicator and bumps a fault event counter. A hold-off counter then runs for `HOLD_CNT` cycles. After that a system reset pulse of `RST_LEN` cycles goes to both cores, and at the end of the pulse the fault state clears. A manual reset request drives the same reset output at once and abandons any fault in progress. While the reset output is high, and for the two clocks after it drops, comparison is suppressed because the delay line does not yet hold valid data. The shared application outputs are the bitwise AND of the two aligned GPIO buses.

Top module: `lockstep_cmp_top`

## Requirements
- R1: After `rst_ni` is released, `fault_o`=0, `sys_rst_o`=0 and `fault_cnt_o`=0.
- R2: When the trailing core's bundle equals the leading core's bundle from two cycles earlier, no fault is raised.
- R3: In a cycle where comparison is enabled, a difference in a qualified field sets `fault_o` from the next cycle. Qualified fields: write strobe, read strobe and GPIO always; address when the trailing core's write or read strobe is 1; write data when the trailing core's write strobe is 1.
- R4: `fault_o` stays 1 after it is set, even when the outputs match again, until the recovery pulse ends or a manual reset occurs.
- R5: If a fault is first seen in cycle t, `sys_rst_o` is 1 in cycles t+HOLD_CNT+1 through t+HOLD_CNT+RST_LEN. `fault_o` is 0 from cycle t+HOLD_CNT+RST_LEN+1.
- R6: A difference in write data while the trailing write strobe is 0 has no effect. So does a difference in address while both trailing strobes are 0.
- R7: No fault is detected in any cycle where `sys_rst_o` is 1, nor in the two cycles after it falls.
- R8: `sys_rst_o` is 1 in any cycle where `man_rst_i` is 1. `fault_o` is 0 in the cycle after, and any hold-off in progress is abandoned.
- R9: `led_o` equals the leading core's GPIO from two cycles earlier ANDed with the trailing core's current GPIO.
- R10: `fault_cnt_o` increments by one on each new fault event (a mismatch while no fault is held) and wraps at its width. Mismatches while a fault is held do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| man_rst_i | input | 1 | Manual reset request, active high |
| a_addr_i | input | ADDR_W | Leading core address |
| a_wdata_i | input | DATA_W | Leading core write data |
| a_we_i | input | 1 | Leading core write strobe |
| a_re_i | input | 1 | Leading core read strobe |
| a_gpio_i | input | GPIO_W | Leading core GPIO outputs |
| b_addr_i | input | ADDR_W | Trailing core address |
| b_wdata_i | input | DATA_W | Trailing core write data |
| b_we_i | input | 1 | Trailing core write strobe |
| b_re_i | input | 1 | Trailing core read strobe |
| b_gpio_i | input | GPIO_W | Trailing core GPIO outputs |
| fault_o | output | 1 | Sticky fault indicator |
| sys_rst_o | output | 1 | Reset to both cores, active high |
| led_o | output | GPIO_W | AND of aligned GPIO outputs |
| fault_cnt_o | output | FCNT_W | Fault event counter |

## Verification
`led_o` and the manual-reset path of `sys_rst_o` are combinational, so they are due in the same cycle as the stimulus. `fault_o` and `fault_cnt_o` move one cycle after the mismatching cycle, and the recovery pulse starts HOLD_CNT+1 cycles after it. The bench drives each cycle's inputs on the falling edge and compares all outputs 1 ns later against a cycle model written from the requirements. The model advances only after that comparison, which matches the register stage before each registered output. Directed checks at fixed cycle offsets cover stickiness, manual reset, the warm-up window and don't-care fields.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned LAG = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_PULSE = 2'd2
  } rec_st_e;
endpackage

// File: rtl/lsc_delay_line.sv
module lsc_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GPIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_we_i,
  input  logic              l_re_i,
  input  logic [GPIO_W-1:0] l_gpio_i,
  input  logic [ADDR_W-1:0] t_addr_i,
  input  logic [DATA_W-1:0] t_wdata_i,
  input  logic              t_we_i,
  input  logic              t_re_i,
  input  logic [GPIO_W-1:0] t_gpio_i,
  output logic              valid_o,
  output logic              mismatch_o
);
  localparam int unsigned WC_W = $clog2(lsc_pkg::LAG + 1);
  localparam logic [WC_W-1:0] WC_FULL = WC_W'(lsc_pkg::LAG);

  logic [WC_W-1:0] warm_q;
  logic            strobe_diff, addr_diff, data_diff, gpio_diff;

  // count loaded edges since last clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (clr_i)           warm_q <= '0;
    else if (warm_q != WC_FULL) warm_q <= warm_q + 1'b1;
  end

  assign valid_o = (warm_q == WC_FULL) && !clr_i;

  always_comb begin
    strobe_diff = (l_we_i != t_we_i) || (l_re_i != t_re_i);
    gpio_diff   = (l_gpio_i != t_gpio_i);
    addr_diff   = (t_we_i || t_re_i) && (l_addr_i != t_addr_i);
    data_diff   = t_we_i && (l_wdata_i != t_wdata_i);
  end

  assign mismatch_o = valid_o && (strobe_diff || gpio_diff || addr_diff || data_diff);

  a_r7_no_cmp_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);
  a_r7_no_mismatch_in_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !mismatch_o);
endmodule

// File: rtl/lsc_recovery.sv
module lsc_recovery #(
  parameter int unsigned HOLD_CNT = 16,
  parameter int unsigned RST_LEN  = 4,
  parameter int unsigned FCNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              mismatch_i,
  output logic              fault_o,
  output logic              pulse_o,
  output logic [FCNT_W-1:0] fcnt_o
);
  import lsc_pkg::*;

  localparam int unsigned HC_W = $clog2(HOLD_CNT + 1);
  localparam int unsigned PC_W = $clog2(RST_LEN + 1);
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_CNT - 1);
  localparam logic [PC_W-1:0] PULSE_LAST = PC_W'(RST_LEN - 1);

  rec_st_e           st_q;
  logic [HC_W-1:0]   hold_q;
  logic [PC_W-1:0]   pcnt_q;
  logic [FCNT_W-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      pcnt_q <= '0;
      fcnt_q <= '0;
    end else if (man_rst_i) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      pcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (mismatch_i) begin
            st_q   <= ST_HOLD;
            hold_q <= '0;
            fcnt_q <= fcnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (hold_q == HOLD_LAST) begin
            st_q   <= ST_PULSE;
            pcnt_q <= '0;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (pcnt_q == PULSE_LAST) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fault_o = (st_q != ST_IDLE);
  assign pulse_o = (st_q == ST_PULSE);
  assign fcnt_o  = fcnt_q;

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !man_rst_i && !(pulse_o && pcnt_q == PULSE_LAST)) |=> fault_o);
  a_r5_pulse_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ($past(hold_q) == HOLD_LAST));
  a_r10_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fcnt_q == $past(fcnt_q)) || (fcnt_q == $past(fcnt_q) + 1'b1));
  a_r10_cnt_only_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fault_o) |-> $stable(fcnt_q));
endmodule

// File: rtl/lockstep_cmp_top.sv
module lockstep_cmp_top #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GPIO_W   = 4,
  parameter int unsigned HOLD_CNT = 16,
  parameter int unsigned RST_LEN  = 4,
  parameter int unsigned FCNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              a_we_i,
  input  logic              a_re_i,
  input  logic [GPIO_W-1:0] a_gpio_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic              b_we_i,
  input  logic              b_re_i,
  input  logic [GPIO_W-1:0] b_gpio_i,
  output logic              fault_o,
  output logic              sys_rst_o,
  output logic [GPIO_W-1:0] led_o,
  output logic [FCNT_W-1:0] fault_cnt_o
);
  localparam int unsigned PW = 2 + ADDR_W + DATA_W + GPIO_W;

  logic [PW-1:0]     lead_v, lead_d;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_wdata;
  logic              ld_we, ld_re;
  logic [GPIO_W-1:0] ld_gpio;
  logic              cmp_valid, mismatch, pulse;

  assign lead_v = {a_we_i, a_re_i, a_addr_i, a_wdata_i, a_gpio_i};

  lsc_delay_line #(.W(PW), .DEPTH(lsc_pkg::LAG)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lead_v),
    .q_o   (lead_d)
  );

  assign {ld_we, ld_re, ld_addr, ld_wdata, ld_gpio} = lead_d;

  lsc_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sys_rst_o),
    .l_addr_i  (ld_addr),
    .l_wdata_i (ld_wdata),
    .l_we_i    (ld_we),
    .l_re_i    (ld_re),
    .l_gpio_i  (ld_gpio),
    .t_addr_i  (b_addr_i),
    .t_wdata_i (b_wdata_i),
    .t_we_i    (b_we_i),
    .t_re_i    (b_re_i),
    .t_gpio_i  (b_gpio_i),
    .valid_o   (cmp_valid),
    .mismatch_o(mismatch)
  );

  lsc_recovery #(.HOLD_CNT(HOLD_CNT), .RST_LEN(RST_LEN), .FCNT_W(FCNT_W)) u_rec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .man_rst_i (man_rst_i),
    .mismatch_i(mismatch),
    .fault_o   (fault_o),
    .pulse_o   (pulse),
    .fcnt_o    (fault_cnt_o)
  );

  assign sys_rst_o = pulse | man_rst_i;
  assign led_o     = ld_gpio & b_gpio_i;

  a_r2_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid |-> (lead_d == $past(lead_v, lsc_pkg::LAG)));
  a_r8_man_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> !fault_o);
  a_r8_man_to_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |-> sys_rst_o);
endmodule

// File: tb/sim_lockstep_cmp_top.sv
`timescale 1ns/1ps
module sim_lockstep_cmp_top;
  localparam int AW = 32, DW = 32, GW = 4, HC = 16, RL = 4, FW = 8;
  localparam int PW = 2 + AW + DW + GW;

  logic clk = 0, rst_ni = 0, man_rst_i = 0;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic a_we, a_re, b_we, b_re;
  logic [GW-1:0] a_gpio, b_gpio;
  logic fault_o, sys_rst_o;
  logic [GW-1:0] led_o;
  logic [FW-1:0] fault_cnt_o;

  int checks = 0, failures = 0;
  logic [PW-1:0] ah1, ah2;
  int m_wc, m_st, m_hold, m_pc;
  logic [FW-1:0] m_fc;

  always #2.5 clk = ~clk;

  lockstep_cmp_top #(.ADDR_W(AW), .DATA_W(DW), .GPIO_W(GW), .HOLD_CNT(HC),
                     .RST_LEN(RL), .FCNT_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .man_rst_i(man_rst_i),
    .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_we_i(a_we), .a_re_i(a_re), .a_gpio_i(a_gpio),
    .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_we_i(b_we), .b_re_i(b_re), .b_gpio_i(b_gpio),
    .fault_o(fault_o), .sys_rst_o(sys_rst_o), .led_o(led_o), .fault_cnt_o(fault_cnt_o));

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit qual_diff(input logic [PW-1:0] l, input logic [PW-1:0] t);
    logic lwe, lre, twe, tre;
    logic [AW-1:0] la, ta;
    logic [DW-1:0] ld, td;
    logic [GW-1:0] lg, tg;
    {lwe, lre, la, ld, lg} = l;
    {twe, tre, ta, td, tg} = t;
    return (lwe != twe) || (lre != tre) || (lg != tg) ||
           ((twe || tre) && (la != ta)) || (twe && (ld != td));
  endfunction

  // kind: 0 clean, 1 gpio, 2 addr(strobe forced), 3 wdata(write forced), 4 we, 5 don't-care only
  task automatic cycle(input bit man, input int kind);
    logic [PW-1:0] bv;
    logic e_rst, mis;
    @(negedge clk);
    a_we = 1'($urandom); a_re = 1'($urandom); a_addr = $urandom; a_wdata = $urandom;
    a_gpio = GW'($urandom);
    bv = ah2;
    case (kind)
      1: bv[GW-1:0] = bv[GW-1:0] ^ GW'(1 << ($urandom % GW));
      2: begin bv[PW-2] = 1'b1; bv[DW+GW +: AW] = bv[DW+GW +: AW] ^ 32'h10; end
      3: begin bv[PW-1] = 1'b1; bv[GW +: DW] = bv[GW +: DW] ^ 32'h1; end
      4: bv[PW-1] = ~bv[PW-1];
      5: begin
        if (!bv[PW-1]) bv[GW +: DW] = ~bv[GW +: DW];
        if (!bv[PW-1] && !bv[PW-2]) bv[DW+GW +: AW] = ~bv[DW+GW +: AW];
      end
      default: ;
    endcase
    if (kind == 2 || kind == 3) ah2 = ah2; // lead keeps its value; strobe mismatch may add to it
    {b_we, b_re, b_addr, b_wdata, b_gpio} = bv;
    man_rst_i = man;
    #1;
    e_rst = (m_st == 2) || man;
    chk("R3", "fault_o", 64'(fault_o), 64'(m_st != 0));
    chk("R5", "sys_rst_o", 64'(sys_rst_o), 64'(e_rst));
    chk("R9", "led_o", 64'(led_o), 64'(ah2[GW-1:0] & bv[GW-1:0]));
    chk("R10", "fault_cnt_o", 64'(fault_cnt_o), 64'(m_fc));
    mis = (m_wc == 2) && !e_rst && qual_diff(ah2, bv);
    // model advance at the coming edge
    if (man) begin m_st = 0; m_hold = 0; m_pc = 0; end
    else case (m_st)
      0: if (mis) begin m_st = 1; m_hold = 0; m_fc = m_fc + 1'b1; end
      1: if (m_hold == HC - 1) begin m_st = 2; m_pc = 0; end else m_hold++;
      2: if (m_pc == RL - 1) begin m_st = 0; m_hold = 0; end else m_pc++;
      default: m_st = 0;
    endcase
    if (e_rst) m_wc = 0; else if (m_wc < 2) m_wc++;
    ah2 = ah1;
    ah1 = {a_we, a_re, a_addr, a_wdata, a_gpio};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [FW-1:0] snap;
    void'($urandom(32'h1F2E3D4C));
    {a_we, a_re, a_addr, a_wdata, a_gpio} = '0;
    {b_we, b_re, b_addr, b_wdata, b_gpio} = '0;
    ah1 = '0; ah2 = '0; m_wc = 0; m_st = 0; m_hold = 0; m_pc = 0; m_fc = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    #1;
    chk("R1", "fault_o", 64'(fault_o), 0);
    chk("R1", "sys_rst_o", 64'(sys_rst_o), 0);
    chk("R1", "fault_cnt_o", 64'(fault_cnt_o), 0);

    repeat (200) cycle(0, 0);
    chk("R2", "fault_o clean", 64'(fault_o), 0);
    chk("R2", "fault_cnt_o clean", 64'(fault_cnt_o), 0);

    repeat (150) cycle(0, 5);
    chk("R6", "fault_cnt_o dont-care", 64'(fault_cnt_o), 0);
    chk("R6", "fault_o dont-care", 64'(fault_o), 0);

    // single gpio fault then clean: sticky, then recovery
    cycle(0, 1);
    chk("R3", "fault_o before edge", 64'(fault_o), 0);
    cycle(0, 0);
    chk("R3", "fault_o next cycle", 64'(fault_o), 1);
    repeat (5) cycle(0, 0);
    chk("R4", "fault_o sticky", 64'(fault_o), 1);
    repeat (HC - 6) cycle(0, 0);
    chk("R5", "sys_rst_o at t+HC", 64'(sys_rst_o), 0);
    cycle(0, 0);
    chk("R5", "sys_rst_o at t+HC+1", 64'(sys_rst_o), 1);
    repeat (RL - 1) cycle(0, 0);
    chk("R5", "sys_rst_o last pulse", 64'(sys_rst_o), 1);
    cycle(0, 0);
    chk("R5", "fault_o cleared", 64'(fault_o), 0);
    chk("R10", "one event", 64'(fault_cnt_o), 1);

    // repeated mismatches while held count once
    repeat (5) cycle(0, 0);
    cycle(0, 3); cycle(0, 2); cycle(0, 4); cycle(0, 1);
    chk("R10", "held mismatches count once", 64'(fault_cnt_o), 2);

    // manual reset during hold-off
    cycle(1, 0);
    chk("R8", "sys_rst_o follows manual", 64'(sys_rst_o), 1);
    cycle(0, 0);
    chk("R8", "fault_o after manual", 64'(fault_o), 0);
    repeat (HC + RL + 4) cycle(0, 0);
    chk("R8", "hold-off abandoned", 64'(fault_o), 0);

    // mismatches in warm-up window are ignored
    snap = fault_cnt_o;
    cycle(1, 1);
    cycle(0, 1); cycle(0, 1);
    cycle(0, 0);
    chk("R7", "warm-up ignored cnt", 64'(fault_cnt_o), 64'(snap));
    chk("R7", "warm-up ignored flag", 64'(fault_o), 0);
    cycle(0, 1);
    cycle(0, 0);
    chk("R7", "compare live after warm-up", 64'(fault_o), 1);

    for (int i = 0; i < 3000; i++) begin
      int k;
      k = ($urandom % 50 == 0) ? 1 + int'($urandom % 4) : (($urandom % 2 == 0) ? 5 : 0);
      cycle(($urandom % 400) == 0, k);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule